// File: doc/BRIEF.md
# Staged-Fill Instruction Translation Buffer

This block is a small fully associative translation buffer for instruction fetch. Software never writes the array directly. It first writes a virtual address into a tag holding register, which takes only the page-number field. It then issues a page table entry write. When that second write retires, the held tag and the entry data are committed together, in one cycle, into the slot named by a round-robin replacement pointer. The pointer then moves on by one slot.

Alongside the fill path, the block performs a combinational lookup of a virtual address against all valid slots. It returns a hit flag, the stored entry bits and the slot number. A flush-all pulse invalidates every slot and leaves the replacement pointer where it is. Page walks, permission checks and address-space tagging belong to the surrounding logic. The stored entry bits are passed through untouched.

Top module: `itlb_stage_fill`

## Requirements
- R1: A tag write (`tag_wr_en`) loads only the holding register; with no commit in the same cycle, no slot changes and a later lookup of that page misses.
- R2: The stored tag is the virtual page number, bits 47:13 of the 48-bit address (8 KB pages); bits 12:0 of both the tag-write and the lookup address are ignored.
- R3: A commit happens in a cycle with both `pte_wr_en` and `pte_retire` high; the held tag and `pte_wr_data` go into one slot, whose valid bit is set.
- R4: The first commit after reset goes to slot 0; each commit advances the pointer by one, wrapping from slot 7 back to slot 0.
- R5: `pte_wr_en` without `pte_retire` (a squashed write), or `pte_retire` without `pte_wr_en`, commits nothing and leaves the pointer unchanged.
- R6: A lookup hits when a valid slot holds the address's page number; `lookup_hit` is then 1, `lookup_pte` carries that slot's entry and `lookup_idx` its number; on a miss all three are 0.
- R7: When several valid slots match, the lowest-numbered slot is reported.
- R8: A lookup in the same cycle as a commit sees the array as it stood before that commit.
- R9: `flush_all` clears every valid bit from the next cycle on; neither a flush nor any lookup or hit moves the replacement pointer.
- R10: A flush and a commit in the same cycle leave the target slot invalid, and the pointer still advances.
- R11: A tag write in the same cycle as a commit does not affect that commit, which uses the tag held before the edge; the new tag serves the next commit.
- R12: After reset every slot is invalid, the pointer is at slot 0 and the holding register holds page number 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tag_wr_en | input | 1 | Write the tag holding register |
| tag_wr_va | input | 48 | Virtual address whose bits 47:13 are held |
| pte_wr_en | input | 1 | Page table entry write issued |
| pte_wr_data | input | 32 | Entry bits to store |
| pte_retire | input | 1 | The issued entry write retires this cycle |
| flush_all | input | 1 | Invalidate every slot |
| lookup_va | input | 48 | Virtual address to translate |
| lookup_hit | output | 1 | A valid slot matches |
| lookup_pte | output | 32 | Entry bits of the reported slot, 0 on miss |
| lookup_idx | output | 3 | Number of the reported slot, 0 on miss |

## Verification
A wrong replacement pointer shows up as a wrong `lookup_idx` on the first lookup after the commit that used it. A pointer that moves on a squashed write, a lookup or a flush shows up the same way. A stale or early-loaded holding register shows up as a miss, or as a hit under the wrong page, one cycle after the commit it fed. A lost or wrongly set valid bit is visible on the next cycle's lookup. Because the outputs are combinational, a bench that compares them against a behavioural model on every cycle catches any such fault within one cycle of the commit or flush that exposes it.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
   // Implementation choice for the replacement pointer.
   typedef enum logic [0:0] {
      PTR_BINARY = 1'b0,
      PTR_RING   = 1'b1
   } ptr_style_e;
endpackage

// File: rtl/itlb_rr_ptr.sv
module itlb_rr_ptr
   import itlb_pkg::*;
#(
   parameter int         ENTRIES = 8,
   parameter ptr_style_e STYLE   = PTR_BINARY,
   localparam int        IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] idx
);

   generate
      if (STYLE == PTR_BINARY) begin : g_bin
         logic [IDX_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (adv)
               cnt_q <= (cnt_q == IDX_W'(ENTRIES - 1)) ? '0 : cnt_q + 1'b1;
         end
         assign idx = cnt_q;
      end else begin : g_ring
         logic [ENTRIES-1:0] ring_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ring_q <= ENTRIES'(1);
            else if (adv)
               ring_q <= {ring_q[ENTRIES-2:0], ring_q[ENTRIES-1]};
         end
         always_comb begin
            idx = '0;
            for (int i = 0; i < ENTRIES; i++)
               if (ring_q[i]) idx = idx | IDX_W'(i);
         end
         // R4: exactly one slot is ever selected
         p_ring_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot(ring_q));
      end
   endgenerate

   // R5, R9: without a commit the pointer holds
   p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(idx));

   // R4: a commit at the last slot wraps to slot 0
   p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && idx == IDX_W'(ENTRIES - 1)) |=> (idx == '0));

endmodule

// File: rtl/itlb_entry_array.sv
module itlb_entry_array #(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 35,
   parameter int PTE_W   = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [IDX_W-1:0]                wr_idx,
   input  logic [TAG_W-1:0]                wr_tag,
   input  logic [PTE_W-1:0]                wr_pte,
   input  logic                            flush,
   output logic [ENTRIES-1:0]              valid_o,
   output logic [ENTRIES-1:0][TAG_W-1:0]   tag_o,
   output logic [ENTRIES-1:0][PTE_W-1:0]   pte_o
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            valid_o[e] <= 1'b0;
         else if (flush)
            valid_o[e] <= 1'b0;
         else if (sel)
            valid_o[e] <= 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_o[e] <= '0;
            pte_o[e] <= '0;
         end else if (sel) begin
            tag_o[e] <= wr_tag;
            pte_o[e] <= wr_pte;
         end
      end
   end

   // R9, R10: a flush leaves no valid slot
   p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_o == '0));

   // R3: a commit without flush leaves its slot valid
   p_commit_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush) |=> valid_o[$past(wr_idx)]);

   // R1: no commit and no flush means the array is untouched
   p_quiet_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !flush) |=> ($stable(valid_o) && $stable(tag_o) && $stable(pte_o)));

endmodule

// File: rtl/itlb_match_sel.sv
module itlb_match_sel #(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 35,
   parameter int PTE_W   = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]            valid,
   input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
   input  logic [ENTRIES-1:0][PTE_W-1:0] ptes,
   input  logic [TAG_W-1:0]              key,
   output logic                          hit,
   output logic [IDX_W-1:0]              idx,
   output logic [PTE_W-1:0]              pte
);

   logic [ENTRIES-1:0] match;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match[e] = valid[e] && (tags[e] == key);
   end

   // Scan from the top so the lowest matching slot is written last.
   always_comb begin
      hit = 1'b0;
      idx = '0;
      pte = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit = 1'b1;
            idx = IDX_W'(i);
            pte = ptes[i];
         end
      end
   end

endmodule

// File: rtl/itlb_stage_fill.sv
module itlb_stage_fill
   import itlb_pkg::*;
#(
   parameter int         ENTRIES   = 8,
   parameter int         VA_W      = 48,
   parameter int         PAGE_LSB  = 13,
   parameter int         PTE_W     = 32,
   parameter ptr_style_e PTR_STYLE = PTR_BINARY,
   localparam int        TAG_W     = VA_W - PAGE_LSB,
   localparam int        IDX_W     = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tag_wr_en,
   input  logic [VA_W-1:0]  tag_wr_va,
   input  logic             pte_wr_en,
   input  logic [PTE_W-1:0] pte_wr_data,
   input  logic             pte_retire,
   input  logic             flush_all,
   input  logic [VA_W-1:0]  lookup_va,
   output logic             lookup_hit,
   output logic [PTE_W-1:0] lookup_pte,
   output logic [IDX_W-1:0] lookup_idx
);

   generate
      if (ENTRIES < 2)
         $error("itlb_stage_fill: ENTRIES must be at least 2");
      if (PAGE_LSB < 1 || PAGE_LSB >= VA_W)
         $error("itlb_stage_fill: PAGE_LSB out of range");
      if (PTE_W < 1)
         $error("itlb_stage_fill: PTE_W must be positive");
   endgenerate

   logic [TAG_W-1:0]              tag_hold_q;
   logic                          commit;
   logic [IDX_W-1:0]              wr_ptr;
   logic [ENTRIES-1:0]            valid;
   logic [ENTRIES-1:0][TAG_W-1:0] tags;
   logic [ENTRIES-1:0][PTE_W-1:0] ptes;
   logic [TAG_W-1:0]              lookup_key;
   logic                          unused_offsets;

   assign unused_offsets = ^{tag_wr_va[PAGE_LSB-1:0], lookup_va[PAGE_LSB-1:0]};
   assign lookup_key     = lookup_va[VA_W-1:PAGE_LSB];
   assign commit         = pte_wr_en && pte_retire;

   // Staging register for the page number; lives outside the array.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tag_hold_q <= '0;
      else if (tag_wr_en)
         tag_hold_q <= tag_wr_va[VA_W-1:PAGE_LSB];
   end

   itlb_rr_ptr #(
      .ENTRIES (ENTRIES),
      .STYLE   (PTR_STYLE)
   ) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (commit),
      .idx   (wr_ptr)
   );

   itlb_entry_array #(
      .ENTRIES (ENTRIES),
      .TAG_W   (TAG_W),
      .PTE_W   (PTE_W)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (commit),
      .wr_idx  (wr_ptr),
      .wr_tag  (tag_hold_q),
      .wr_pte  (pte_wr_data),
      .flush   (flush_all),
      .valid_o (valid),
      .tag_o   (tags),
      .pte_o   (ptes)
   );

   itlb_match_sel #(
      .ENTRIES (ENTRIES),
      .TAG_W   (TAG_W),
      .PTE_W   (PTE_W)
   ) u_match (
      .valid (valid),
      .tags  (tags),
      .ptes  (ptes),
      .key   (lookup_key),
      .hit   (lookup_hit),
      .idx   (lookup_idx),
      .pte   (lookup_pte)
   );

   // R3, R11: the slot receives the tag held before the commit edge and the written entry
   p_commit_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (tags[$past(wr_ptr)] == $past(tag_hold_q)) &&
                 (ptes[$past(wr_ptr)] == $past(pte_wr_data)));

   // R6: a reported hit names a valid slot holding the looked-up page
   p_hit_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lookup_hit |-> (valid[lookup_idx] && tags[lookup_idx] == lookup_key));

   // R6: a miss drives zero data and index
   p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !lookup_hit |-> (lookup_pte == '0 && lookup_idx == '0));

   // R1: a tag write alone leaves the valid bits untouched
   p_tag_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_wr_en && !commit && !flush_all) |=> $stable(valid));

endmodule

// File: tb/itlb_stage_fill_test.sv
module itlb_stage_fill_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tag_wr_en = 1'b0;
   logic [47:0] tag_wr_va = '0;
   logic        pte_wr_en = 1'b0;
   logic [31:0] pte_wr_data = '0;
   logic        pte_retire = 1'b0;
   logic        flush_all = 1'b0;
   logic [47:0] lookup_va = '0;
   logic        lookup_hit;
   logic [31:0] lookup_pte;
   logic [2:0]  lookup_idx;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   // behavioural reference state
   logic [34:0] m_tag [8];
   logic [31:0] m_pte [8];
   bit          m_val [8];
   int          m_ptr;
   logic [34:0] m_hold;

   always #4 clk = ~clk;  // 125 MHz

   itlb_stage_fill uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tag_wr_en   (tag_wr_en),
      .tag_wr_va   (tag_wr_va),
      .pte_wr_en   (pte_wr_en),
      .pte_wr_data (pte_wr_data),
      .pte_retire  (pte_retire),
      .flush_all   (flush_all),
      .lookup_va   (lookup_va),
      .lookup_hit  (lookup_hit),
      .lookup_pte  (lookup_pte),
      .lookup_idx  (lookup_idx)
   );

   function automatic logic [47:0] mkva(input logic [34:0] vpn, input logic [12:0] off);
      return {vpn, off};
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 8; i++) begin
         m_tag[i] = '0; m_pte[i] = '0; m_val[i] = 1'b0;
      end
      m_ptr = 0;
      m_hold = '0;
   endtask

   task automatic check(input string req);
      bit          eh = 1'b0;
      int          ei = 0;
      logic [31:0] ep = '0;
      for (int i = 7; i >= 0; i--)
         if (m_val[i] && m_tag[i] == lookup_va[47:13]) begin
            eh = 1'b1; ei = i; ep = m_pte[i];
         end
      tests++;
      if (lookup_hit !== eh || lookup_idx !== 3'(ei) || lookup_pte !== ep) begin
         fails++;
         $display("FAIL %s: got hit=%0b idx=%0d pte=%h, expected hit=%0b idx=%0d pte=%h",
                  req, lookup_hit, lookup_idx, lookup_pte, eh, ei, ep);
      end
   endtask

   // Compare before the edge, then advance model and design together.
   task automatic step(input string req);
      #1;
      check(req);
      @(posedge clk);
      if (pte_wr_en && pte_retire) begin
         m_tag[m_ptr] = m_hold;
         m_pte[m_ptr] = pte_wr_data;
         m_val[m_ptr] = 1'b1;
         m_ptr = (m_ptr + 1) % 8;
      end
      if (flush_all)
         for (int i = 0; i < 8; i++) m_val[i] = 1'b0;
      if (tag_wr_en) m_hold = tag_wr_va[47:13];
      @(negedge clk);
      tag_wr_en = 1'b0; pte_wr_en = 1'b0; pte_retire = 1'b0; flush_all = 1'b0;
   endtask

   task automatic fill(input logic [34:0] vpn, input logic [31:0] pte, input string req);
      tag_wr_en = 1'b1; tag_wr_va = mkva(vpn, 13'h1ABC);
      step(req);
      pte_wr_en = 1'b1; pte_retire = 1'b1; pte_wr_data = pte;
      step(req);
   endtask

   task automatic probe(input logic [34:0] vpn, input logic [12:0] off, input string req);
      lookup_va = mkva(vpn, off);
      step(req);
   endtask

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            tests++; fails++;
            $display("FAIL watchdog: got %0d cycles, expected under 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
         end
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R12: reset state, everything misses
      probe(35'h0, 13'h0, "R12 reset empty");
      rst_n = 1'b1;
      @(negedge clk);
      probe(35'h0, 13'h0, "R12 holding tag zero, no slot valid");

      // R1: tag write only
      tag_wr_en = 1'b1; tag_wr_va = mkva(35'h123, 13'h0);
      step("R1 tag write");
      probe(35'h123, 13'h0, "R1 tag write does not fill array");

      // R3, R4: first commit lands in slot 0
      pte_wr_en = 1'b1; pte_retire = 1'b1; pte_wr_data = 32'hA000_0001;
      lookup_va = mkva(35'h123, 13'h0);
      step("R8 same-cycle lookup sees old array");
      probe(35'h123, 13'h0, "R3 R4 first commit to slot 0");
      // R2: offset bits ignored
      probe(35'h123, 13'h1FFF, "R2 offset bits ignored");
      probe(35'h124, 13'h0, "R2 neighbouring page misses");

      // R5: squashed and stray strobes
      tag_wr_en = 1'b1; tag_wr_va = mkva(35'h200, 13'h0);
      step("R5 stage tag");
      pte_wr_en = 1'b1; pte_wr_data = 32'hDEAD_0000;
      step("R5 squashed write");
      pte_retire = 1'b1;
      step("R5 retire without write");
      probe(35'h200, 13'h0, "R5 nothing committed");
      pte_wr_en = 1'b1; pte_retire = 1'b1; pte_wr_data = 32'hA000_0002;
      step("R5 real commit");
      probe(35'h200, 13'h0, "R5 pointer unmoved, slot 1");

      // R9: lookups and hits do not move the pointer
      for (int k = 0; k < 4; k++) probe(35'h123, 13'(k), "R9 repeated hits");

      // R11: tag write and commit in the same cycle
      tag_wr_en = 1'b1; tag_wr_va = mkva(35'h300, 13'h0);
      step("R11 stage 300");
      tag_wr_en = 1'b1; tag_wr_va = mkva(35'h301, 13'h0);
      pte_wr_en = 1'b1; pte_retire = 1'b1; pte_wr_data = 32'hA000_0003;
      step("R11 overlap");
      probe(35'h300, 13'h0, "R11 commit used old tag");
      probe(35'h301, 13'h0, "R11 new tag not yet committed");
      pte_wr_en = 1'b1; pte_retire = 1'b1; pte_wr_data = 32'hA000_0004;
      step("R11 commit new tag");
      probe(35'h301, 13'h0, "R11 new tag in slot 3");

      // R7: duplicate tag, lowest slot wins
      fill(35'h123, 32'hB000_0123, "R7 duplicate fill");
      probe(35'h123, 13'h0, "R7 lowest slot wins");

      // R4: wrap past slot 7
      for (int k = 0; k < 4; k++)
         fill(35'h400 + 35'(k), 32'hC000_0000 + 32'(k), "R4 fill to wrap");
      for (int k = 0; k < 4; k++)
         probe(35'h400 + 35'(k), 13'h0, "R4 filled slots");
      probe(35'h123, 13'h0, "R4 R7 slot 0 overwritten, slot 4 now lowest");
      probe(35'h403, 13'h0, "R4 wrapped into slot 0");

      // R9: flush clears valid, pointer kept
      flush_all = 1'b1; lookup_va = mkva(35'h403, 13'h0);
      step("R9 flush cycle still sees old array");
      probe(35'h403, 13'h0, "R9 flush invalidates");
      probe(35'h123, 13'h0, "R9 flush invalidates all");
      fill(35'h500, 32'hD000_0500, "R9 fill after flush");
      probe(35'h500, 13'h0, "R9 pointer continues at slot 1");

      // R10: flush and commit together
      tag_wr_en = 1'b1; tag_wr_va = mkva(35'h600, 13'h0);
      step("R10 stage");
      pte_wr_en = 1'b1; pte_retire = 1'b1; pte_wr_data = 32'hE000_0600; flush_all = 1'b1;
      step("R10 flush with commit");
      probe(35'h600, 13'h0, "R10 slot left invalid");
      fill(35'h601, 32'hE000_0601, "R10 next fill");
      probe(35'h601, 13'h0, "R10 pointer advanced to slot 3");

      // R6: miss output zeros after everything
      probe(35'h7FF, 13'h0, "R6 miss drives zeros");

      // R12: reset mid-run
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      probe(35'h601, 13'h0, "R12 reset clears slots");
      rst_n = 1'b1;
      @(negedge clk);
      pte_wr_en = 1'b1; pte_retire = 1'b1; pte_wr_data = 32'hF000_0000;
      step("R12 commit with reset holding tag");
      probe(35'h0, 13'h0, "R12 page 0 in slot 0 after reset");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule